// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector with Register File

This block chooses, for each of the two ALU operands of the instruction in the execute stage, where that operand's value comes from. The operand can be read from the register file. It can also be taken from the result held one stage ahead, in the memory stage, or from the result held two stages ahead, in the writeback stage. The block compares the two source register numbers of the execute-stage instruction with the destination numbers of the two older instructions. For each operand it drives a 2-bit select to the mux in front of the ALU. When both older stages match, the newer one (the memory stage) wins.

The block also holds the architectural register file: 32 words of 32 bits, two read ports and one write port. The write port is fed by the writeback stage. A read of the register being written in the same cycle returns the incoming value, so a decode-stage read never sees a stale word. Register 0 is hard-wired to zero. Writes to register 0 are dropped, and register 0 never acts as a bypass source. The ALU, the data memory and the pipeline registers lie outside this block.

Top module: `opnd_fwd`

## Requirements
- R1: `selA` is 2'b10 (memory-stage source) when `memRegWrite` is 1, `memRd` is nonzero and `memRd` equals `exRs`.
- R2: `selA` is 2'b01 (writeback-stage source) when `wbRegWrite` is 1, `wbRd` is nonzero, `wbRd` equals `exRs`, and the R1 condition does not hold.
- R3: When the memory-stage and writeback-stage conditions both hold for an operand, the select is 2'b10. The newer result wins.
- R4: Otherwise the select is 2'b00 (register file). This covers a clear write flag, a destination of register 0, or no match. The value 2'b11 never appears.
- R5: `selB` obeys R1 to R4 using `exRt` in place of `exRs`, independently of `selA`.
- R6: On a rising clock edge with `wbRegWrite` at 1 and `wbRd` nonzero, register `wbRd` takes `wbData`. Later reads of that register return it until it is written again.
- R7: A read on port A or B of the register being written in the same cycle (`wbRegWrite` 1, `wbRd` nonzero and equal to the read address) returns `wbData` combinationally.
- R8: Reading register 0 always returns zero. A write aimed at register 0 has no effect.
- R9: An active-low `rstN` clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| exRs | input | 5 | First source register of execute-stage instruction |
| exRt | input | 5 | Second source register of execute-stage instruction |
| memRd | input | 5 | Destination register of memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | 5 | Destination register of writeback-stage instruction; also write address |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register; also write enable |
| wbData | input | 32 | Writeback result, register file write data |
| selA | output | 2 | Mux select for operand A: 00 file, 01 writeback, 10 memory |
| selB | output | 2 | Mux select for operand B, same encoding |
| rdAddrA | input | 5 | Register file read address, port A |
| rdAddrB | input | 5 | Register file read address, port B |
| rdDataA | output | 32 | Read data, port A |
| rdDataB | output | 32 | Read data, port B |

## Verification
Several functions can land in one cycle. The writeback stage can be committing a register while a decode-stage read asks for that same register, and while the execute stage also names it as a source, with the memory stage sometimes naming it too. The stimulus draws every register number from a small pool that includes register 0. That makes triple coincidences, writes to register 0 and simultaneous double matches frequent. Each cycle, a behavioural model with its own register array predicts both selects and both read words. The bench compares them against the design's outputs. A mismatch is reported against the requirement whose condition applied in that cycle.

// File: rtl/opnd_fwd_pkg.sv
package opnd_fwd_pkg;
  parameter int DATA_W    = 32;
  parameter int REG_COUNT = 32;
  parameter int ADDR_W    = $clog2(REG_COUNT);
  parameter int NUM_OPS   = 2;

  typedef enum logic [1:0] {
    SEL_FILE = 2'b00,
    SEL_WB   = 2'b01,
    SEL_MEM  = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
  } rfStrobe_t;
endpackage

// File: rtl/opnd_fwd_ctrl.sv
module opnd_fwd_ctrl
  import opnd_fwd_pkg::*;
(
  input  logic [NUM_OPS-1:0][ADDR_W-1:0] srcIdx,
  input  logic [ADDR_W-1:0]              memRd,
  input  logic                           memRegWrite,
  input  logic [ADDR_W-1:0]              wbRd,
  input  logic                           wbRegWrite,
  output logic [NUM_OPS-1:0][1:0]        opSel,
  output rfStrobe_t                      rfStb
);
  logic memLive;
  logic wbLive;

  assign memLive = memRegWrite && (memRd != '0);
  assign wbLive  = wbRegWrite && (wbRd != '0);

  assign rfStb.wrEn   = wbLive;
  assign rfStb.wrAddr = wbRd;

  for (genvar g = 0; g < NUM_OPS; g++) begin : gOp
    logic memHit;
    logic wbHit;
    fwdSel_e pick;
    assign memHit = memLive && (memRd == srcIdx[g]);
    assign wbHit  = wbLive && (wbRd == srcIdx[g]);
    always_comb begin
      if (memHit)     pick = SEL_MEM;
      else if (wbHit) pick = SEL_WB;
      else            pick = SEL_FILE;
    end
    assign opSel[g] = pick;
  end
endmodule

// File: rtl/opnd_fwd_regfile.sv
module opnd_fwd_regfile
  import opnd_fwd_pkg::*;
#(
  parameter int NUM_RD = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  rfStrobe_t                      rfStb,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rdIdx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdVal
);
  logic [DATA_W-1:0] regs [REG_COUNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (rfStb.wrEn && (rfStb.wrAddr != '0)) begin
      regs[rfStb.wrAddr] <= wrData;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : gRd
    always_comb begin
      if (rdIdx[p] == '0)
        rdVal[p] = '0;
      else if (rfStb.wrEn && (rfStb.wrAddr == rdIdx[p]))
        rdVal[p] = wrData;
      else
        rdVal[p] = regs[rdIdx[p]];
    end
  end
endmodule

// File: rtl/opnd_fwd.sv
module opnd_fwd
  import opnd_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] exRs,
  input  logic [ADDR_W-1:0] exRt,
  input  logic [ADDR_W-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [ADDR_W-1:0] wbRd,
  input  logic              wbRegWrite,
  input  logic [DATA_W-1:0] wbData,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [NUM_OPS-1:0][ADDR_W-1:0] srcIdx;
  logic [NUM_OPS-1:0][1:0]        opSel;
  logic [1:0][ADDR_W-1:0]         rdIdx;
  logic [1:0][DATA_W-1:0]         rdVal;
  rfStrobe_t                      rfStb;

  assign srcIdx = {exRt, exRs};
  assign selA   = opSel[0];
  assign selB   = opSel[1];
  assign rdIdx  = {rdAddrB, rdAddrA};
  assign rdDataA = rdVal[0];
  assign rdDataB = rdVal[1];

  opnd_fwd_ctrl uCtrl (
    .srcIdx      (srcIdx),
    .memRd       (memRd),
    .memRegWrite (memRegWrite),
    .wbRd        (wbRd),
    .wbRegWrite  (wbRegWrite),
    .opSel       (opSel),
    .rfStb       (rfStb)
  );

  opnd_fwd_regfile #(.NUM_RD(2)) uRf (
    .clk    (clk),
    .rstN   (rstN),
    .rfStb  (rfStb),
    .wrData (wbData),
    .rdIdx  (rdIdx),
    .rdVal  (rdVal)
  );
endmodule

// File: rtl/opnd_fwd_chk.sv
module opnd_fwd_chk
  import opnd_fwd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] exRs,
  input logic [ADDR_W-1:0] exRt,
  input logic [ADDR_W-1:0] memRd,
  input logic              memRegWrite,
  input logic [ADDR_W-1:0] wbRd,
  input logic              wbRegWrite,
  input logic [DATA_W-1:0] wbData,
  input logic [1:0]        selA,
  input logic [1:0]        selB,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB
);
  // R1
  mem_src_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRegWrite && memRd != '0 && memRd == exRs) |-> selA == 2'b10);
  // R3
  mem_over_wb_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRegWrite && memRd != '0 && memRd == exRt && wbRegWrite && wbRd == exRt) |-> selB == 2'b10);
  // R4
  no_bad_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    selA != 2'b11 && selB != 2'b11);
  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    exRs == '0 |-> selA == 2'b00);
  // R7
  same_cycle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbRegWrite && wbRd != '0 && rdAddrA == wbRd) |-> rdDataA == wbData);
  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAddrB == '0 |-> rdDataB == '0);
  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbRegWrite && wbRd != '0) |=>
      (!(rdAddrA == $past(wbRd) && !(wbRegWrite && wbRd == rdAddrA)) || rdDataA == $past(wbData)));
endmodule

bind opnd_fwd opnd_fwd_chk chk (.*);

// File: tb/tb_opnd_fwd.sv
module tb_opnd_fwd;
  logic        clk = 0;
  logic        rstN = 0;
  logic [4:0]  exRs = 0, exRt = 0, memRd = 0, wbRd = 0, rdAddrA = 0, rdAddrB = 0;
  logic        memRegWrite = 0, wbRegWrite = 0;
  logic [31:0] wbData = 0;
  logic [1:0]  selA, selB;
  logic [31:0] rdDataA, rdDataB;

  int checks = 0;
  int errors = 0;
  logic [31:0] refRegs [32];
  bit done = 0;

  always #10 clk = ~clk;

  opnd_fwd dut (.*);

  function automatic logic [1:0] expSel(logic [4:0] src);
    if (memRegWrite && memRd != 0 && memRd == src) return 2'b10;
    if (wbRegWrite && wbRd != 0 && wbRd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string selTag(logic [4:0] src, string side);
    bit m = memRegWrite && memRd != 0 && memRd == src;
    bit w = wbRegWrite && wbRd != 0 && wbRd == src;
    if (m && w) return {side, " R3"};
    if (m) return {side, " R1"};
    if (w) return {side, " R2"};
    return {side, " R4"};
  endfunction

  function automatic logic [31:0] expRd(logic [4:0] a);
    if (a == 0) return 0;
    if (wbRegWrite && wbRd == a) return wbData;
    return refRegs[a];
  endfunction

  function automatic string rdTag(logic [4:0] a);
    if (a == 0) return "R8";
    if (wbRegWrite && wbRd == a) return "R7";
    return "R6";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare at the falling edge, then advance the model for the coming rising edge
  task automatic stepCheck(string extra);
    @(negedge clk);
    chk({selTag(exRs, "selA"), extra}, {30'd0, selA}, {30'd0, expSel(exRs)});
    chk({selTag(exRt, "selB R5"), extra}, {30'd0, selB}, {30'd0, expSel(exRt)});
    chk({"rdA ", rdTag(rdAddrA), extra}, rdDataA, expRd(rdAddrA));
    chk({"rdB ", rdTag(rdAddrB), extra}, rdDataB, expRd(rdAddrB));
    if (wbRegWrite && wbRd != 0) refRegs[wbRd] = wbData;
    @(posedge clk); #1;
  endtask

  function automatic logic [4:0] pickReg();
    int k = $urandom_range(0, 5);
    case (k)
      0: return 5'd0;
      1: return 5'd1;
      2: return 5'd2;
      3: return 5'd3;
      4: return 5'd31;
      default: return 5'($urandom_range(0, 31));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) refRegs[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R9: every register reads zero after reset
    for (int i = 0; i < 32; i += 2) begin
      rdAddrA = 5'(i); rdAddrB = 5'(i + 1);
      stepCheck(" R9");
    end
    // R6 / R7: write register 5, read in same cycle and next cycle
    wbRegWrite = 1; wbRd = 5; wbData = 32'hCAFE0005; rdAddrA = 5; rdAddrB = 6;
    stepCheck(" dir");
    wbRegWrite = 0; stepCheck(" dir");
    // R8: write to register 0 ignored
    wbRegWrite = 1; wbRd = 0; wbData = 32'hDEADBEEF; rdAddrA = 0; rdAddrB = 0;
    exRs = 0; memRegWrite = 1; memRd = 0;
    stepCheck(" dir");
    wbRegWrite = 0; stepCheck(" dir");
    // R3 with R5: both stages match both operands
    memRegWrite = 1; memRd = 7; wbRegWrite = 1; wbRd = 7; wbData = 32'h77;
    exRs = 7; exRt = 7; stepCheck(" dir");
    // R2: only writeback matches on Rt, memory matches on Rs
    memRd = 8; exRs = 8; exRt = 7; stepCheck(" dir");
    // R4: flags clear
    memRegWrite = 0; wbRegWrite = 0; stepCheck(" dir");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      exRs = pickReg(); exRt = pickReg(); memRd = pickReg(); wbRd = pickReg();
      rdAddrA = pickReg(); rdAddrB = pickReg();
      memRegWrite = 1'($urandom_range(0, 1));
      wbRegWrite = 1'($urandom_range(0, 1));
      wbData = $urandom();
      stepCheck(" rnd");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule